// File: doc/BRIEF.md
# Dual-Channel Picture-in-Picture Window Layout Generator

This block sits beside a raster timing generator. On every clock it takes the current pixel column and line number. It decides whether that screen position falls inside a window of the Main channel, inside a window of the Sub channel, or inside neither. For each channel it also reports which window was hit and the pixel and line offsets inside that window, so that a downstream fetch stage can address the picture data.

Each channel places a grid of windows. There are 1 to 4 rows, spaced vertically by a programmable pitch. Each row holds 1 to 4 windows. A row's window count and its horizontal pitch are chosen per row, and the pitch is picked from a table of four horizontal distances. All windows of a channel share one width and one height. A priority bit decides which channel is drawn on top where windows of the two channels cover the same position.

Software programs the layout through a byte-wide write port into a staging copy. The staged geometry becomes active only on a frame-start pulse, so a field is never drawn with a mix of old and new geometry.

Top module: `pip_layout`

## Requirements
- R1: A window in column c of row r covers the pixels from 4*HS + 4*c*HD to 4*HS + 4*c*HD + 4*(W+1) - 1, both ends included. HS is the channel's horizontal start, W is its width field, and HD is the horizontal distance entry chosen by that row.
- R2: Row r covers the lines from VS + r*VD to VS + r*VD + H, both ends included. VS is the vertical start, VD is the row pitch and H is the height field, so the height is H+1 lines.
- R3: The row count field n (2 bits) shows rows 0..n. A value of 0 still shows one row.
- R4: The per-row configuration byte holds the window count in bits [1:0], where a value m shows columns 0..m. Bits [3:2] select which of the four horizontal distance entries that row uses.
- R5: sel_o is encoded 0 for none, 1 for Main and 2 for Sub. Where both channels hit, a priority bit of 0 selects Sub and a priority bit of 1 selects Main. Where only one channel hits, that channel is selected.
- R6: A channel whose enable bit is 0 reports no hit anywhere, whatever its row and window counts.
- R7: When a channel hits, its window index output is {row, column}, and dx/dy give the offset from that window's top-left corner. If windows of one channel overlap, the window with the lowest row-major index is reported. When a channel does not hit, its index, dx and dy read 0.
- R8: All outputs are registered and reflect the pixel and line inputs of the previous clock. After reset all outputs are 0 and both channels are disabled.
- R9: Writes go to a staging copy. The active geometry, enables and priority change only at a clock edge where frame_start_i is 1. A write in that same cycle is included.
- R10: Register map. Bit 4 of the address selects the channel (0 Main, 1 Sub). The low nibble selects the register: 0 horizontal start, 1 vertical start, 2 width, 3 height, 4 row count, 5 row pitch, 6..9 horizontal distances 0..3, and 10..13 the configuration bytes for rows 0..3. Address 0x0F is control: bit 0 priority, bit 1 Main enable, bit 2 Sub enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 8 | Register write data |
| frame_start_i | input | 1 | Loads the staged registers into the active set |
| pix_x_i | input | PIX_W | Current pixel column |
| line_y_i | input | LINE_W | Current line |
| sel_o | output | 2 | Visible channel: 0 none, 1 Main, 2 Sub |
| main_hit_o | output | 1 | Main window hit |
| main_win_o | output | 4 | Main window index {row, col} |
| main_dx_o | output | 10 | Pixel offset in the Main window |
| main_dy_o | output | 8 | Line offset in the Main window |
| sub_hit_o | output | 1 | Sub window hit |
| sub_win_o | output | 4 | Sub window index {row, col} |
| sub_dx_o | output | 10 | Pixel offset in the Sub window |
| sub_dy_o | output | 8 | Line offset in the Sub window |

## Verification
The bench probes the last pixel and last line of a window and the position just past each of them. An off-by-one in the width or height term would stretch or shrink every window and show up there. It places a row with the largest count against a row count field of 0, and a channel that is disabled while its counts are nonzero. A decoder that treats a count field as the number of windows, or that ignores the enable, would then show windows that should be absent. It stacks windows with a horizontal distance of 0, which catches a priority chain that reports the highest index instead of the lowest. It also writes geometry without a frame pulse, which exposes a design whose active registers follow the staging copy at once.

// File: rtl/pip_layout_pkg.sv
package pip_layout_pkg;
    localparam int N_ROW = 4;
    localparam int N_COL = 4;
    localparam int WIN_W = 4;
    localparam int DX_W  = 10;
    localparam int DY_W  = 8;

    typedef struct packed {
        logic [7:0]            hstart;
        logic [7:0]            vstart;
        logic [7:0]            width;
        logic [7:0]            height;
        logic [1:0]            rows;
        logic [7:0]            vdist;
        logic [N_ROW-1:0][7:0] hdist;
        logic [N_ROW-1:0][1:0] wcnt;
        logic [N_ROW-1:0][1:0] hsel;
    } chan_cfg_t;

    typedef struct packed {
        logic       prio;
        logic [1:0] en;   // [0] main, [1] sub
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MAIN = 2'd1,
        SEL_SUB  = 2'd2
    } sel_e;
endpackage

// File: rtl/pip_layout_regs.sv
module pip_layout_regs
    import pip_layout_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic [4:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       frame_start_i,
    output chan_cfg_t  main_cfg_o,
    output chan_cfg_t  sub_cfg_o,
    output ctrl_t      ctrl_o
);
    typedef struct packed {
        chan_cfg_t [1:0] pend;
        ctrl_t           pend_ctrl;
        chan_cfg_t [1:0] act;
        ctrl_t           act_ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        logic       ch;
        logic [3:0] idx;
        logic [3:0] off;
        r_d = r_q;
        ch  = wr_addr_i[4];
        idx = wr_addr_i[3:0];
        off = 4'd0;
        if (wr_en_i) begin
            unique case (idx)
                4'd0:  r_d.pend[ch].hstart = wr_data_i;
                4'd1:  r_d.pend[ch].vstart = wr_data_i;
                4'd2:  r_d.pend[ch].width  = wr_data_i;
                4'd3:  r_d.pend[ch].height = wr_data_i;
                4'd4:  r_d.pend[ch].rows   = wr_data_i[1:0];
                4'd5:  r_d.pend[ch].vdist  = wr_data_i;
                4'd6, 4'd7, 4'd8, 4'd9: begin
                    off = idx - 4'd6;
                    r_d.pend[ch].hdist[off[1:0]] = wr_data_i;
                end
                4'd10, 4'd11, 4'd12, 4'd13: begin
                    off = idx - 4'd10;
                    r_d.pend[ch].wcnt[off[1:0]] = wr_data_i[1:0];
                    r_d.pend[ch].hsel[off[1:0]] = wr_data_i[3:2];
                end
                4'd15: begin
                    r_d.pend_ctrl.prio = wr_data_i[0];
                    r_d.pend_ctrl.en   = wr_data_i[2:1];
                end
                default: ;
            endcase
        end
        if (frame_start_i) begin
            r_d.act      = r_d.pend;
            r_d.act_ctrl = r_d.pend_ctrl;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign main_cfg_o = r_q.act[0];
    assign sub_cfg_o  = r_q.act[1];
    assign ctrl_o     = r_q.act_ctrl;

    AST_ACTIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_start_i |=> ($stable(r_q.act) && $stable(r_q.act_ctrl))); // R9
endmodule

// File: rtl/pip_layout_chan.sv
module pip_layout_chan
    import pip_layout_pkg::*;
#(
    parameter int CW = 14,
    parameter int CL = 12
) (
    input  chan_cfg_t         cfg_i,
    input  logic              en_i,
    input  logic [CW-1:0]     x_i,
    input  logic [CL-1:0]     y_i,
    output logic              hit_o,
    output logic [WIN_W-1:0]  win_o,
    output logic [DX_W-1:0]   dx_o,
    output logic [DY_W-1:0]   dy_o
);
    // Scan from the highest index down so the lowest hit index is kept last.
    always_comb begin
        hit_o = 1'b0;
        win_o = '0;
        dx_o  = '0;
        dy_o  = '0;
        for (int r = N_ROW - 1; r >= 0; r--) begin
            for (int c = N_COL - 1; c >= 0; c--) begin
                logic [7:0]    hd;
                logic [CW-1:0] x0;
                logic [CW-1:0] xw;
                logic [CL-1:0] y0;
                logic          in_x;
                logic          in_y;
                logic          live;
                hd   = cfg_i.hdist[cfg_i.hsel[r]];
                x0   = CW'({cfg_i.hstart, 2'b00}) + CW'(c) * CW'({hd, 2'b00});
                xw   = CW'({cfg_i.width, 2'b00}) + CW'(4);
                y0   = CL'(cfg_i.vstart) + CL'(r) * CL'(cfg_i.vdist);
                in_x = (x_i >= x0) && (x_i < x0 + xw);
                in_y = (y_i >= y0) && (y_i <= y0 + CL'(cfg_i.height));
                live = en_i && (2'(r) <= cfg_i.rows) && (2'(c) <= cfg_i.wcnt[r]);
                if (live && in_x && in_y) begin
                    hit_o = 1'b1;
                    win_o = {2'(r), 2'(c)};
                    dx_o  = DX_W'(x_i - x0);
                    dy_o  = DY_W'(y_i - y0);
                end
            end
        end
    end
endmodule

// File: rtl/pip_layout.sv
module pip_layout
    import pip_layout_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [4:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              frame_start_i,
    input  logic [PIX_W-1:0]  pix_x_i,
    input  logic [LINE_W-1:0] line_y_i,
    output logic [1:0]        sel_o,
    output logic              main_hit_o,
    output logic [3:0]        main_win_o,
    output logic [9:0]        main_dx_o,
    output logic [7:0]        main_dy_o,
    output logic              sub_hit_o,
    output logic [3:0]        sub_win_o,
    output logic [9:0]        sub_dx_o,
    output logic [7:0]        sub_dy_o
);
    // Wide enough for 4*255 + 3*4*255 + 4*256 and the largest counter.
    localparam int CW = ((PIX_W > 13) ? PIX_W : 13) + 1;
    localparam int CL = ((LINE_W > 10) ? LINE_W : 10) + 1;

    typedef struct packed {
        sel_e                 sel;
        logic [1:0]           hit;
        logic [1:0][WIN_W-1:0] win;
        logic [1:0][DX_W-1:0] dx;
        logic [1:0][DY_W-1:0] dy;
    } out_t;

    chan_cfg_t main_cfg, sub_cfg;
    ctrl_t     ctrl;

    pip_layout_regs u_regs (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .frame_start_i (frame_start_i),
        .main_cfg_o    (main_cfg),
        .sub_cfg_o     (sub_cfg),
        .ctrl_o        (ctrl)
    );

    chan_cfg_t            cfg_w [2];
    logic      [1:0]      hit_w;
    logic [WIN_W-1:0]     win_w [2];
    logic [DX_W-1:0]      dx_w  [2];
    logic [DY_W-1:0]      dy_w  [2];

    assign cfg_w[0] = main_cfg;
    assign cfg_w[1] = sub_cfg;

    for (genvar g = 0; g < 2; g++) begin : g_chan
        pip_layout_chan #(.CW(CW), .CL(CL)) u_chan (
            .cfg_i (cfg_w[g]),
            .en_i  (ctrl.en[g]),
            .x_i   (CW'(pix_x_i)),
            .y_i   (CL'(line_y_i)),
            .hit_o (hit_w[g]),
            .win_o (win_w[g]),
            .dx_o  (dx_w[g]),
            .dy_o  (dy_w[g])
        );
    end

    out_t o_d, o_q;

    always_comb begin
        o_d = '0;
        for (int k = 0; k < 2; k++) begin
            o_d.hit[k] = hit_w[k];
            o_d.win[k] = win_w[k];
            o_d.dx[k]  = dx_w[k];
            o_d.dy[k]  = dy_w[k];
        end
        if (hit_w[0] && hit_w[1]) o_d.sel = ctrl.prio ? SEL_MAIN : SEL_SUB;
        else if (hit_w[0])        o_d.sel = SEL_MAIN;
        else if (hit_w[1])        o_d.sel = SEL_SUB;
        else                      o_d.sel = SEL_NONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    assign sel_o      = o_q.sel;
    assign main_hit_o = o_q.hit[0];
    assign main_win_o = o_q.win[0];
    assign main_dx_o  = o_q.dx[0];
    assign main_dy_o  = o_q.dy[0];
    assign sub_hit_o  = o_q.hit[1];
    assign sub_win_o  = o_q.win[1];
    assign sub_dx_o   = o_q.dx[1];
    assign sub_dy_o   = o_q.dy[1];

    AST_MAIN_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl.en[0] |=> !main_hit_o); // R6
    AST_SUB_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl.en[1] |=> !sub_hit_o); // R6
    AST_PRIO_MAIN_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl.prio |=> (!(main_hit_o && sub_hit_o) || sel_o == SEL_MAIN)); // R5
    AST_PRIO_SUB_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl.prio |=> (!(main_hit_o && sub_hit_o) || sel_o == SEL_SUB)); // R5
    AST_NONE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_o == SEL_NONE) |-> (!main_hit_o && !sub_hit_o)); // R5
    AST_ROW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (!main_hit_o || main_win_o[3:2] <= $past(main_cfg.rows))); // R3
    AST_DX_IN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (!main_hit_o || main_dx_o[9:2] <= $past(main_cfg.width))); // R1
    AST_DY_IN_HEIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (!main_hit_o || main_dy_o <= $past(main_cfg.height))); // R2
endmodule

// File: tb/pip_layout_tb_top.sv
module pip_layout_tb_top;
    localparam int PIX_W  = 12;
    localparam int LINE_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              frame_start = 1'b0;
    logic [PIX_W-1:0]  pix_x = '0;
    logic [LINE_W-1:0] line_y = '0;
    logic [1:0]        sel;
    logic              m_hit, s_hit;
    logic [3:0]        m_win, s_win;
    logic [9:0]        m_dx, s_dx;
    logic [7:0]        m_dy, s_dy;

    always #10 clk = ~clk;

    pip_layout #(.PIX_W(PIX_W), .LINE_W(LINE_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .frame_start_i(frame_start), .pix_x_i(pix_x),
        .line_y_i(line_y), .sel_o(sel),
        .main_hit_o(m_hit), .main_win_o(m_win), .main_dx_o(m_dx), .main_dy_o(m_dy),
        .sub_hit_o(s_hit), .sub_win_o(s_win), .sub_dx_o(s_dx), .sub_dy_o(s_dy)
    );

    typedef struct {
        int hs, vs, wd, ht, rw, vd;
        int hd[4];
        int wc[4];
        int hsl[4];
    } bcfg_t;

    bcfg_t pend[2], act[2];
    int    pend_prio, act_prio;
    int    pend_en[2], act_en[2];
    int    n_tests = 0, n_fail = 0;
    bit    done = 1'b0;

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_chan(input int ch);
        int b;
        b = ch * 16;
        wr(b + 0, pend[ch].hs);  wr(b + 1, pend[ch].vs);
        wr(b + 2, pend[ch].wd);  wr(b + 3, pend[ch].ht);
        wr(b + 4, pend[ch].rw);  wr(b + 5, pend[ch].vd);
        for (int i = 0; i < 4; i++) wr(b + 6 + i, pend[ch].hd[i]);
        for (int i = 0; i < 4; i++) wr(b + 10 + i, pend[ch].wc[i] + 4 * pend[ch].hsl[i]);
    endtask

    task automatic push_ctrl();
        wr(15, pend_prio + 2 * pend_en[0] + 4 * pend_en[1]);
    endtask

    task automatic commit();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        act = pend; act_prio = pend_prio; act_en = pend_en;
    endtask

    task automatic model(input int ch, input int x, input int y,
                         output bit h, output int w, output int dx, output int dy);
        h = 0; w = 0; dx = 0; dy = 0;
        if (act_en[ch] == 0) return;
        for (int r = 0; r <= act[ch].rw; r++) begin
            for (int c = 0; c <= act[ch].wc[r]; c++) begin
                int x0, y0;
                x0 = 4 * act[ch].hs + 4 * c * act[ch].hd[act[ch].hsl[r]];
                y0 = act[ch].vs + r * act[ch].vd;
                if (!h && x >= x0 && x < x0 + 4 * (act[ch].wd + 1) &&
                    y >= y0 && y <= y0 + act[ch].ht) begin
                    h = 1; w = 4 * r + c; dx = x - x0; dy = y - y0;
                end
            end
        end
    endtask

    task automatic probe(input int x, input int y, input string tag);
        bit mh, sh; int mw, mdx, mdy, sw, sdx, sdy, es;
        @(negedge clk);
        pix_x = PIX_W'(x); line_y = LINE_W'(y);
        model(0, x, y, mh, mw, mdx, mdy);
        model(1, x, y, sh, sw, sdx, sdy);
        es = (mh && sh) ? (act_prio ? 1 : 2) : mh ? 1 : sh ? 2 : 0;
        @(negedge clk);
        n_tests++;
        if (int'(sel) != es || m_hit != mh || s_hit != sh ||
            int'(m_win) != mw || int'(m_dx) != mdx || int'(m_dy) != mdy ||
            int'(s_win) != sw || int'(s_dx) != sdx || int'(s_dy) != sdy) begin
            n_fail++;
            $display("FAIL %s at (%0d,%0d): actual sel=%0d m=%0d/%0d/%0d/%0d s=%0d/%0d/%0d/%0d expected sel=%0d m=%0d/%0d/%0d/%0d s=%0d/%0d/%0d/%0d",
                     tag, x, y, sel, m_hit, m_win, m_dx, m_dy, s_hit, s_win, s_dx, s_dy,
                     es, mh, mw, mdx, mdy, sh, sw, sdx, sdy);
        end
    endtask

    function automatic bcfg_t zero_cfg();
        bcfg_t z;
        z.hs = 0; z.vs = 0; z.wd = 0; z.ht = 0; z.rw = 0; z.vd = 0;
        for (int i = 0; i < 4; i++) begin z.hd[i] = 0; z.wc[i] = 0; z.hsl[i] = 0; end
        return z;
    endfunction

    function automatic bcfg_t rand_cfg();
        bcfg_t z;
        z.hs = $urandom_range(0, 63); z.vs = $urandom_range(0, 63);
        z.wd = $urandom_range(0, 40); z.ht = $urandom_range(0, 40);
        z.rw = $urandom_range(0, 3);  z.vd = $urandom_range(0, 80);
        for (int i = 0; i < 4; i++) begin
            z.hd[i] = $urandom_range(0, 60);
            z.wc[i] = $urandom_range(0, 3);
            z.hsl[i] = $urandom_range(0, 3);
        end
        return z;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        pend[0] = zero_cfg(); pend[1] = zero_cfg();
        pend_prio = 0; pend_en[0] = 0; pend_en[1] = 0;
        act = pend; act_prio = 0; act_en = pend_en;
        repeat (3) @(negedge clk);
        // R8: reset state
        n_tests++;
        if (sel != 2'd0 || m_hit || s_hit || m_win != 0 || m_dx != 0 || s_dy != 0) begin
            n_fail++;
            $display("FAIL R8 reset: actual sel=%0d mh=%0d sh=%0d expected all zero", sel, m_hit, s_hit);
        end
        rst_n = 1'b1;
        probe(0, 0, "R8");

        // R1 R2 R10: single main window at x 40..59, y 20..29
        pend[0].hs = 10; pend[0].vs = 20; pend[0].wd = 4; pend[0].ht = 9;
        pend_en[0] = 1;
        push_chan(0); push_ctrl(); commit();
        probe(40, 20, "R1"); probe(59, 29, "R2"); probe(60, 20, "R1");
        probe(39, 20, "R1"); probe(40, 30, "R2"); probe(45, 25, "R10");

        // R3: three rows with pitch 30
        pend[0].rw = 2; pend[0].vd = 30;
        push_chan(0); commit();
        probe(40, 80, "R3"); probe(40, 110, "R3"); probe(40, 50, "R3");

        // R4: row 0 four windows at 40 px pitch via entry 2, row 1 single
        pend[0].hd[2] = 10; pend[0].wc[0] = 3; pend[0].hsl[0] = 2;
        push_chan(0); commit();
        probe(160, 20, "R4"); probe(200, 20, "R4"); probe(80, 50, "R4"); probe(199, 29, "R4");

        // R5: sub channel overlapping main
        pend[1] = pend[0]; pend_en[1] = 1; pend_prio = 0;
        push_chan(1); push_ctrl(); commit();
        probe(45, 22, "R5");
        pend_prio = 1; push_ctrl(); commit();
        probe(45, 22, "R5");

        // R6: sub disabled with nonzero counts
        pend_en[1] = 0; push_ctrl(); commit();
        probe(45, 22, "R6"); probe(80, 55, "R6");

        // R9: staged write has no effect until frame start
        pend[0].hs = 100; wr(0, 100);
        probe(40, 20, "R9");
        commit();
        probe(40, 20, "R9"); probe(400, 20, "R9");

        // R7: stacked windows with zero pitch report the lowest index
        pend[0].hd[pend[0].hsl[0]] = 0; pend[0].vd = 0;
        push_chan(0); commit();
        probe(402, 21, "R7"); probe(419, 29, "R7");

        // Random layouts
        for (int k = 0; k < 12; k++) begin
            pend[0] = rand_cfg(); pend[1] = rand_cfg();
            pend_prio = $urandom_range(0, 1);
            pend_en[0] = ($urandom_range(0, 5) != 0) ? 1 : 0;
            pend_en[1] = ($urandom_range(0, 5) != 0) ? 1 : 0;
            push_chan(0); push_chan(1); push_ctrl(); commit();
            for (int p = 0; p < 1500; p++)
                probe($urandom_range(0, 1199), $urandom_range(0, 499), "R7");
        end
        finish_run();
    end
endmodule